// File: doc/BRIEF.md
# Metastable Entropy Skew Servo

This block closes the loop around a flip-flop that is held on the edge of metastability to produce random bits. The flip-flop sees a data edge and a clock edge separated by an effective skew. That skew is the programmed delay plus an unknown routing bias, less a drift caused by voltage and temperature. When the skew is near zero, the sampled bit is a one about half of the time. The servo takes one raw bit per clock and keeps the last 2^W bits in a sliding shift memory. The popcount of that memory is its running estimate of the probability of a one.

Once per window of 2^W clocks, a three-state controller turns the estimate into a delay-line code. In `ST_GATHER` it waits for the window to close, then latches the error (popcount minus 2^(W-1)). In `ST_INTEGRATE` it adds that error into a saturating integrator. In `ST_DRIVE` it loads a new proportional-integral code and updates the lock detector, then returns to `ST_GATHER`. There are three transitions: window closed, integrate done and drive done. The unsigned code drives an external programmable delay line. The raw bit is passed through with one register of delay, and a lock flag reports that the error has stayed small for several windows in a row.

Top module: `trng_skew_servo`

## Requirements
- R1: While reset is held, `delay_code` is mid-scale 2^(CODE_W-1) (32 with defaults), `locked` is 0 and `bit_out` is 0.
- R2: `bit_out` equals the `raw_bit` sampled on the previous rising clock edge.
- R3: With reset released just before rising edge 1, a window closes at every edge that is a multiple of 2^W (256, 512, ...). On the following edge the error is latched as the count of ones among the bits sampled at the last 2^W edges, minus 2^(W-1). The shift memory starts out all zero.
- R4: One edge after the error is latched, the integrator becomes integrator + error, clamped to ±(2^(INTEG_W-1)-1).
- R5: One edge after the integrator update, `delay_code` loads clamp(2^(CODE_W-1) − (error >>> KP_SHIFT) − (integrator >>> KI_SHIFT)), where >>> is an arithmetic shift that rounds toward minus infinity. With defaults this is edge 259 for the first window. A surplus of ones therefore lowers the code.
- R6: `delay_code` saturates at 0 and at 2^CODE_W−1 and never wraps.
- R7: `locked` changes only on a code-load edge. It is 1 after the LOCK_WINDOWS-th consecutive window with |error| < LOCK_THRESH, and it returns to 0 on the load edge of any window whose |error| ≥ LOCK_THRESH.
- R8: The source model sets the probability of a one to (128 + 4·(code + offset − 32))/256. Against that model the loop locks within 120 windows for offsets of +10 and −12, and then holds the code within 3 of 32 − offset. It also relocks after a step between those offsets.
- R9: `delay_code` holds its value on every edge that is not a code-load edge, so it changes at most once per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one raw bit is taken per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_bit | input | 1 | Sampled output of the metastable flip-flop |
| delay_code | output | CODE_W | Unsigned code for the programmable delay line |
| bit_out | output | 1 | Raw bit, registered once |
| locked | output | 1 | Error has been inside the threshold for LOCK_WINDOWS windows |

## Verification
A corrupted history bit or popcount shows as a wrong error at the next window close, visible on `delay_code` three edges after that close. So any such fault appears at the ports within one window plus three clocks. A damaged integrator or wrong shift direction keeps pushing the code the wrong way, so the loop either runs into a rail or never locks. A state machine that skips or repeats a state moves the code-load edge away from the 2^W + 3 spacing, which the clock-by-clock comparison catches at the first window.

// File: rtl/trng_servo_pkg.sv
package trng_servo_pkg;

    // Controller phases within one history window
    typedef enum logic [1:0] {
        ST_GATHER    = 2'd0,
        ST_INTEGRATE = 2'd1,
        ST_DRIVE     = 2'd2
    } servo_state_t;

endpackage

// File: rtl/trng_hist_window.sv
module trng_hist_window #(
    parameter int HIST_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 raw_bit,
    output logic [HIST_LOG2:0]   weight,
    output logic                 win_rdy
);
    localparam int DEPTH = 2 ** HIST_LOG2;
    localparam logic [HIST_LOG2-1:0] CNT_LAST = HIST_LOG2'(DEPTH - 1);

    logic [DEPTH-1:0]     hist_q;
    logic [HIST_LOG2-1:0] cnt_q;
    logic                 leaving;

    assign leaving = hist_q[DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-2:0], raw_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            weight <= '0;
        end else begin
            unique case ({raw_bit, leaving})
                2'b10:   weight <= weight + (HIST_LOG2+1)'(1);
                2'b01:   weight <= weight - (HIST_LOG2+1)'(1);
                default: weight <= weight;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            win_rdy <= 1'b0;
        end else begin
            cnt_q   <= cnt_q + HIST_LOG2'(1);
            win_rdy <= (cnt_q == CNT_LAST);
        end
    end

    // R3
    weight_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        weight <= (HIST_LOG2+1)'(DEPTH));

    // R3
    weight_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(weight) == weight) || ($past(weight) + (HIST_LOG2+1)'(1) == weight)
        || ($past(weight) == weight + (HIST_LOG2+1)'(1)));

endmodule

// File: rtl/trng_pi_ctrl.sv
module trng_pi_ctrl
    import trng_servo_pkg::*;
#(
    parameter int HIST_LOG2 = 8,
    parameter int CODE_W    = 6,
    parameter int KP_SHIFT  = 3,
    parameter int KI_SHIFT  = 4,
    parameter int INTEG_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_rdy,
    input  logic [HIST_LOG2:0]          weight,
    output logic signed [HIST_LOG2+1:0] err_q,
    output logic                        upd,
    output logic [CODE_W-1:0]           code
);
    localparam int EW   = HIST_LOG2 + 2;
    localparam int SW   = ((INTEG_W > EW) ? INTEG_W : EW) + 3;
    localparam int HALF = 2 ** (HIST_LOG2 - 1);
    localparam int IMAX = 2 ** (INTEG_W - 1) - 1;
    localparam int CMAX = 2 ** CODE_W - 1;
    localparam int MID  = 2 ** (CODE_W - 1);

    servo_state_t state, state_n;

    logic signed [INTEG_W-1:0] integ_q;
    logic signed [SW-1:0]      integ_sum;
    logic signed [INTEG_W-1:0] integ_n;
    logic signed [SW-1:0]      code_sum;
    logic [CODE_W-1:0]         code_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_GATHER;
        end else begin
            state <= state_n;
        end
    end

    // Next state
    always_comb begin
        unique case (state)
            ST_GATHER:    state_n = win_rdy ? ST_INTEGRATE : ST_GATHER;
            ST_INTEGRATE: state_n = ST_DRIVE;
            ST_DRIVE:     state_n = ST_GATHER;
            default:      state_n = ST_GATHER;
        endcase
    end

    // Saturating integrator sum
    always_comb begin
        integ_sum = SW'(integ_q) + SW'(err_q);
        if (integ_sum > SW'(IMAX)) begin
            integ_n = INTEG_W'(IMAX);
        end else if (integ_sum < -SW'(IMAX)) begin
            integ_n = -INTEG_W'(IMAX);
        end else begin
            integ_n = integ_sum[INTEG_W-1:0];
        end
    end

    // Proportional-integral code with clamping
    always_comb begin
        code_sum = SW'(MID) - SW'(err_q >>> KP_SHIFT) - SW'(integ_q >>> KI_SHIFT);
        if (code_sum < SW'(0)) begin
            code_n = '0;
        end else if (code_sum > SW'(CMAX)) begin
            code_n = CODE_W'(CMAX);
        end else begin
            code_n = code_sum[CODE_W-1:0];
        end
    end

    // Outputs and datapath per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= '0;
            integ_q <= '0;
            code    <= CODE_W'(MID);
        end else begin
            unique case (state)
                ST_GATHER: begin
                    if (win_rdy) begin
                        err_q <= $signed({1'b0, weight}) - EW'(HALF);
                    end
                end
                ST_INTEGRATE: integ_q <= integ_n;
                ST_DRIVE:     code    <= code_n;
                default: ;
            endcase
        end
    end

    assign upd = (state == ST_DRIVE);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DRIVE) |=> $stable(code));

    // R4
    integ_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
        integ_q >= -INTEG_W'(IMAX));

    // R3
    state_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEGRATE) |=> (state == ST_DRIVE));

endmodule

// File: rtl/trng_lock_detect.sv
module trng_lock_detect #(
    parameter int HIST_LOG2    = 8,
    parameter int LOCK_THRESH  = 32,
    parameter int LOCK_WINDOWS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd,
    input  logic signed [HIST_LOG2+1:0] err,
    output logic                        locked
);
    localparam int EW = HIST_LOG2 + 2;
    localparam int GW = $clog2(LOCK_WINDOWS + 1);
    localparam logic [GW-1:0] GOOD_FULL = GW'(LOCK_WINDOWS);

    logic [GW-1:0] good_q, good_n;
    logic          in_band;

    assign in_band = (err < EW'(LOCK_THRESH)) && (err > -EW'(LOCK_THRESH));

    always_comb begin
        if (!in_band) begin
            good_n = '0;
        end else if (good_q == GOOD_FULL) begin
            good_n = good_q;
        end else begin
            good_n = good_q + GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (upd) begin
            good_q <= good_n;
            locked <= in_band && (good_n == GOOD_FULL);
        end
    end

    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !in_band) |=> !locked);

    // R7
    lock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(upd));

endmodule

// File: rtl/trng_skew_servo.sv
module trng_skew_servo #(
    parameter int HIST_LOG2    = 8,
    parameter int CODE_W       = 6,
    parameter int KP_SHIFT     = 3,
    parameter int KI_SHIFT     = 4,
    parameter int INTEG_W      = 12,
    parameter int LOCK_THRESH  = 32,
    parameter int LOCK_WINDOWS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_bit,
    output logic [CODE_W-1:0] delay_code,
    output logic              bit_out,
    output logic              locked
);
    localparam int EW = HIST_LOG2 + 2;

    logic [HIST_LOG2:0]   weight;
    logic                 win_rdy;
    logic signed [EW-1:0] err;
    logic                 upd;
    logic                 past_ok;

    trng_hist_window #(.HIST_LOG2(HIST_LOG2)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_bit (raw_bit),
        .weight  (weight),
        .win_rdy (win_rdy)
    );

    trng_pi_ctrl #(
        .HIST_LOG2 (HIST_LOG2),
        .CODE_W    (CODE_W),
        .KP_SHIFT  (KP_SHIFT),
        .KI_SHIFT  (KI_SHIFT),
        .INTEG_W   (INTEG_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_rdy (win_rdy),
        .weight  (weight),
        .err_q   (err),
        .upd     (upd),
        .code    (delay_code)
    );

    trng_lock_detect #(
        .HIST_LOG2    (HIST_LOG2),
        .LOCK_THRESH  (LOCK_THRESH),
        .LOCK_WINDOWS (LOCK_WINDOWS)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .err    (err),
        .locked (locked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            bit_out <= raw_bit;
            past_ok <= 1'b1;
        end
    end

    // R2
    bit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (bit_out == $past(raw_bit)));

endmodule

// File: tb/trng_skew_servo_tb.sv
module trng_skew_servo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 256;
    localparam int HALF  = 128;
    localparam int MID   = 32;
    localparam int CMAX  = 63;
    localparam int IMAX  = 2047;
    localparam int KP    = 3;
    localparam int KI    = 4;
    localparam int THR   = 32;
    localparam int NWIN  = 4;

    localparam int SRC_ONES  = 0;
    localparam int SRC_ZEROS = 1;
    localparam int SRC_LOOP  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_bit = 1'b0;
    logic [5:0] delay_code;
    logic       bit_out;
    logic       locked;

    int checks = 0;
    int failures = 0;
    int edges = 0;
    int src_mode = SRC_ONES;
    int offset = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    trng_skew_servo u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_bit    (raw_bit),
        .delay_code (delay_code),
        .bit_out    (bit_out),
        .locked     (locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, state after each edge
    bit hq[$];
    int m_cnt, m_rdy, m_phase, m_err, m_integ, m_code, m_good, m_lock, m_bit;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq.delete();
            for (int i = 0; i < WIN; i++) hq.push_back(1'b0);
            m_cnt = 0; m_rdy = 0; m_phase = 0; m_err = 0; m_integ = 0;
            m_code = MID; m_good = 0; m_lock = 0; m_bit = 0;
            edges = 0;
        end else begin
            edges++;
            if (m_phase == 0) begin
                if (m_rdy != 0) begin
                    int s;
                    s = 0;
                    foreach (hq[i]) s += int'(hq[i]);
                    m_err = s - HALF;
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_integ = m_integ + m_err;
                if (m_integ > IMAX) m_integ = IMAX;
                if (m_integ < -IMAX) m_integ = -IMAX;
                m_phase = 2;
            end else begin
                int t;
                t = MID - (m_err >>> KP) - (m_integ >>> KI);
                m_code = (t < 0) ? 0 : ((t > CMAX) ? CMAX : t);
                if (m_err < THR && m_err > -THR) begin
                    m_good = (m_good < NWIN) ? m_good + 1 : NWIN;
                end else begin
                    m_good = 0;
                end
                m_lock = (m_good == NWIN) ? 1 : 0;
                m_phase = 0;
            end
            m_rdy = (m_cnt == WIN - 1) ? 1 : 0;
            m_cnt = (m_cnt + 1) % WIN;
            hq.push_back(raw_bit);
            void'(hq.pop_front());
            m_bit = int'(raw_bit);
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(delay_code) == m_code, "R5", "code vs model", int'(delay_code), m_code);
            chk(int'(locked) == m_lock, "R7", "lock vs model", int'(locked), m_lock);
            chk(int'(bit_out) == m_bit, "R2", "bit_out vs model", int'(bit_out), m_bit);
        end
    end

    // Source model driven on the falling edge
    always @(negedge clk) begin
        int s, th;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        s = int'(delay_code) + offset - MID;
        th = HALF + 4 * s;
        if (th < 0) th = 0;
        if (th > WIN) th = WIN;
        case (src_mode)
            SRC_ONES:  raw_bit = 1'b1;
            SRC_ZEROS: raw_bit = 1'b0;
            default:   raw_bit = (int'(lfsr[7:0]) < th);
        endcase
    end

    task automatic wait_neg(input int n);
        while (edges < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_lock(input string req, input int max_win);
        int n;
        n = 0;
        while (!locked && n < max_win * WIN) begin
            @(negedge clk);
            n++;
        end
        chk(locked == 1'b1, req, "lock within window bound", int'(locked), 1);
    endtask

    initial begin
        src_mode = SRC_ONES;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int'(delay_code) == MID, "R1", "reset code", int'(delay_code), MID);
        chk(locked == 1'b0, "R1", "reset lock", int'(locked), 0);
        chk(bit_out == 1'b0, "R1", "reset bit_out", int'(bit_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 code still mid-scale just before the first load edge
        wait_neg(258);
        chk(int'(delay_code) == MID, "R9", "hold before load", int'(delay_code), MID);
        // R3 R4 R5: all ones -> err 128, integ 128, code 32-16-8
        wait_neg(259);
        chk(int'(delay_code) == 8, "R3", "first window code", int'(delay_code), 8);
        wait_neg(511);
        @(posedge clk);
        #1 src_mode = SRC_ZEROS;
        // R6: second window of ones, integ 256 -> code 32-16-16 = 0
        wait_neg(515);
        chk(int'(delay_code) == 0, "R6", "low rail reached", int'(delay_code), 0);
        // R4: zeros window, err -128, integ 128 -> code 32+16-8 = 40
        wait_neg(771);
        chk(int'(delay_code) == 40, "R4", "integrator unwind code", int'(delay_code), 40);
        chk(locked == 1'b0, "R7", "no lock with large error", int'(locked), 0);

        // R8 closed loop, positive offset
        do_reset();
        @(posedge clk);
        #1 begin src_mode = SRC_LOOP; offset = 10; end
        wait_lock("R8", 120);
        chk((int'(delay_code) >= 19) && (int'(delay_code) <= 25), "R8", "code near 22",
            int'(delay_code), 22);

        // R7 lock drops after a step in bias, then R8 relock
        @(posedge clk);
        #1 offset = -12;
        begin
            int n;
            n = 0;
            while (locked && n < 3 * WIN + 4) begin
                @(negedge clk);
                n++;
            end
        end
        chk(locked == 1'b0, "R7", "lock drops on bias step", int'(locked), 0);
        wait_lock("R8", 120);
        chk((int'(delay_code) >= 41) && (int'(delay_code) <= 47), "R8", "code near 44",
            int'(delay_code), 44);

        // R6 high rail with an uncancellable negative bias
        do_reset();
        @(posedge clk);
        #1 offset = -60;
        wait_neg(40 * WIN);
        chk(int'(delay_code) == CMAX, "R6", "high rail", int'(delay_code), CMAX);
        chk(locked == 1'b0, "R7", "no lock at rail", int'(locked), 0);

        // R6 low rail with an uncancellable positive bias
        do_reset();
        @(posedge clk);
        #1 offset = 60;
        wait_neg(40 * WIN);
        chk(int'(delay_code) == 0, "R6", "low rail", int'(delay_code), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule